// File: doc/BRIEF.md
# Serial PHY Management Frame Controller

This block issues station-management read and write frames to an external Ethernet PHY over a two-wire interface: a management clock (MDC) and a bidirectional data line (MDIO). The data line is driven through an output value and an output enable, and it is sampled through a separate input. A host starts each access through three registers: control, address and data. Every accepted access produces exactly one 64-bit frame. For a read, the bits the PHY returns are placed in the data register when the frame ends.

The PHY address does not come from the host. It is captured once from a configuration value that is presented after reset, and the same address is then used for every frame. The address 1Fh is reserved. It is also the value held before any configuration arrives, so a request made before configuration, or made against a configured 1Fh, is refused: no frame is started and an error flag is raised.

The MDC rate is set by a divider field in the control register. MDC stays low while no frame is in progress.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, busy, done, req_err, mdc and mdio_oe are 0 and phy_addr reads 1Fh.
- R2: The first cfg_load pulse after reset captures cfg_phy_addr into phy_addr. Later cfg_load pulses leave phy_addr unchanged until the next reset.
- R3: A start request made while phy_addr is 1Fh starts no frame: busy stays 0, MDC stays low and req_err becomes 1. The next accepted request clears req_err.
- R4: Host writes use reg_sel 0 for control, 1 for address and 2 for data. In the control register, bit 0 set requests a frame, bit 1 selects a read (1) or a write (0), and bits [15:8] hold the divider value h. The address register takes the PHY register number from bits [4:0]. A frame is sent MSB first and consists of 32 ones, then 0,1, then the opcode (1,0 for a read, 0,1 for a write), then the 5-bit PHY address, then the 5-bit register address, then 2 turnaround bits, then 16 data bits.
- R5: On a write frame, mdio_oe is 1 for all 64 bits, the turnaround is driven as 1 then 0, and the data bits carry the data register.
- R6: On a read frame, mdio_oe is 0 for the two turnaround bits and the 16 data bits. The data bits are sampled on the rising MDC edges, and at the end of the frame they appear on rd_data.
- R7: While a frame runs, MDC is low for h+1 clock cycles and then high for h+1 clock cycles for each bit. MDIO changes only while MDC is low. MDC is low whenever busy is 0.
- R8: busy rises in the cycle after the request is accepted and stays high until the falling MDC edge that ends bit 63. At that edge, busy falls and done pulses high for exactly one cycle.
- R9: Host writes to any register while busy is 1 are ignored. They start no frame and change neither the register address, the data register nor the stored request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Configuration strobe that carries the PHY address |
| cfg_phy_addr | input | 5 | PHY address presented with cfg_load |
| reg_wr_en | input | 1 | Host register write strobe |
| reg_sel | input | 2 | Host register select: 0 control, 1 address, 2 data |
| reg_wdata | input | 16 | Host write data |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse at the end of a frame |
| req_err | output | 1 | The last request was refused because of the reserved address |
| rd_data | output | 16 | Contents of the data register |
| phy_addr | output | 5 | Stored PHY address |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | Sampled MDIO level |
| mdio_o | output | 1 | Driven MDIO level |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
The assertions take for granted that the host writes through reg_wr_en one register per cycle. They also assume cfg_load is a clean pulse and that mdio_i is a resolved 0 or 1 whenever MDC rises during a read. The bench meets these conditions. It drives every input on the falling system-clock edge, and it holds reg_wr_en for a single cycle. Its PHY model changes mdio_i only on falling MDC edges, so the level is stable across every rising edge at which the controller samples.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int FRAME_BITS = 64;
  localparam int REGA_W     = 5;
  localparam int PHYA_W     = 5;
  localparam int WORD_W     = 16;
  localparam int TA_FIRST   = 46;
  localparam int DATA_FIRST = 48;
  localparam logic [PHYA_W-1:0] RESERVED_PHY = 5'h1F;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_DATA = 2'd2
  } reg_sel_e;

  typedef struct packed {
    logic              rd;
    logic [PHYA_W-1:0] phy;
    logic [REGA_W-1:0] rega;
    logic [WORD_W-1:0] wdata;
  } mgmt_req_t;

  // Complete frame, first transmitted bit in position 63. Released bits are filled with ones.
  function automatic logic [FRAME_BITS-1:0] frame_bits(input mgmt_req_t r);
    logic [1:0]        op;
    logic [1:0]        ta;
    logic [WORD_W-1:0] dat;
    op  = r.rd ? 2'b10 : 2'b01;
    ta  = r.rd ? 2'b11 : 2'b10;
    dat = r.rd ? {WORD_W{1'b1}} : r.wdata;
    return {32'hFFFF_FFFF, 2'b01, op, r.phy, r.rega, ta, dat};
  endfunction

  // Output-enable pattern: a read releases the turnaround and the data bits.
  function automatic logic [FRAME_BITS-1:0] drive_mask(input logic rd);
    return {{TA_FIRST{1'b1}}, {(FRAME_BITS-TA_FIRST){~rd}}};
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             mdc,
  output logic             rise_evt,
  output logic             fall_evt
);
  logic [DIV_W-1:0] cnt;
  logic             wrap;

  assign wrap     = run && (cnt == half);
  assign rise_evt = wrap && !mdc;
  assign fall_evt = wrap && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_cfg_latch.sv
module mdio_cfg_latch
  import mdio_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [PHYA_W-1:0] cfg_addr,
  output logic [PHYA_W-1:0] phy_addr,
  output logic              locked
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phy_addr <= RESERVED_PHY;
      locked   <= 1'b0;
    end else if (cfg_load && !locked) begin
      phy_addr <= cfg_addr;
      locked   <= 1'b1;
    end
  end
endmodule

// File: rtl/mdio_host_regs.sv
module mdio_host_regs
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        sel,
  input  logic [WORD_W-1:0] wdata,
  input  logic              busy,
  input  logic [PHYA_W-1:0] phy_addr,
  input  logic              cap_en,
  input  logic [WORD_W-1:0] cap_data,
  output logic              start,
  output mgmt_req_t         req,
  output logic [DIV_W-1:0]  half,
  output logic              err,
  output logic [WORD_W-1:0] data_q
);
  localparam int DIV_LSB = 8;

  logic              wr_ok;
  logic              go;
  logic              refuse;
  logic [REGA_W-1:0] addr_q;

  assign wr_ok  = wr_en && !busy;
  assign go     = wr_ok && (reg_sel_e'(sel) == SEL_CTRL) && wdata[0];
  assign start  = go && (phy_addr != RESERVED_PHY);
  assign refuse = go && (phy_addr == RESERVED_PHY);

  assign req.rd    = wdata[1];
  assign req.phy   = phy_addr;
  assign req.rega  = addr_q;
  assign req.wdata = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      half   <= '0;
      err    <= 1'b0;
    end else begin
      if (wr_ok && reg_sel_e'(sel) == SEL_CTRL) half <= wdata[DIV_LSB +: DIV_W];
      if (wr_ok && reg_sel_e'(sel) == SEL_ADDR) addr_q <= wdata[REGA_W-1:0];
      if (cap_en) data_q <= cap_data;
      else if (wr_ok && reg_sel_e'(sel) == SEL_DATA) data_q <= wdata;
      if (refuse) err <= 1'b1;
      else if (start) err <= 1'b0;
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  mgmt_req_t         req,
  input  logic              rise_evt,
  input  logic              fall_evt,
  input  logic              mdio_i,
  output logic              active,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              frame_end,
  output logic              cap_en,
  output logic [WORD_W-1:0] cap_data
);
  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(DATA_FIRST);

  logic [IDX_W-1:0]      idx;
  logic [FRAME_BITS-1:0] frame_q;
  logic [FRAME_BITS-1:0] mask_q;
  logic                  rd_q;
  logic [WORD_W-1:0]     shift_q;
  logic [IDX_W-1:0]      pos;

  assign pos       = LAST_IDX - idx;
  assign frame_end = active && fall_evt && (idx == LAST_IDX);
  assign mdio_o    = active && frame_q[pos];
  assign mdio_oe   = active && mask_q[pos];
  assign cap_en    = frame_end && rd_q;
  assign cap_data  = shift_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      idx     <= '0;
      frame_q <= '0;
      mask_q  <= '0;
      rd_q    <= 1'b0;
      shift_q <= '0;
    end else if (start && !active) begin
      active  <= 1'b1;
      idx     <= '0;
      frame_q <= frame_bits(req);
      mask_q  <= drive_mask(req.rd);
      rd_q    <= req.rd;
    end else if (active) begin
      if (rise_evt && rd_q && idx >= DATA_IDX) shift_q <= {shift_q[WORD_W-2:0], mdio_i};
      if (fall_evt) begin
        if (idx == LAST_IDX) active <= 1'b0;
        else idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [PHYA_W-1:0] cfg_phy_addr,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_sel,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic              busy,
  output logic              done,
  output logic              req_err,
  output logic [WORD_W-1:0] rd_data,
  output logic [PHYA_W-1:0] phy_addr,
  output logic              mdc,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe
);
  logic              cfg_locked;
  logic              start;
  mgmt_req_t         req;
  logic [DIV_W-1:0]  half;
  logic              rise_evt;
  logic              fall_evt;
  logic              frame_end;
  logic              cap_en;
  logic [WORD_W-1:0] cap_data;

  mdio_cfg_latch u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_addr(cfg_phy_addr),
    .phy_addr(phy_addr), .locked(cfg_locked)
  );

  mdio_host_regs #(.DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .sel(reg_sel), .wdata(reg_wdata),
    .busy(busy), .phy_addr(phy_addr), .cap_en(cap_en), .cap_data(cap_data),
    .start(start), .req(req), .half(half), .err(req_err), .data_q(rd_data)
  );

  mdio_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .half(half),
    .mdc(mdc), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  mdio_frame_engine u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .req(req),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .mdio_i(mdio_i),
    .active(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .frame_end(frame_end), .cap_en(cap_en), .cap_data(cap_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) done <= 1'b0;
    else        done <= frame_end;
  end
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr_en,
  input logic [1:0]  reg_sel,
  input logic [15:0] reg_wdata,
  input logic        busy,
  input logic        done,
  input logic        req_err,
  input logic [15:0] rd_data,
  input logic [4:0]  phy_addr,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        cfg_locked,
  input logic        frame_end
);
  assert_phy_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_locked && $past(cfg_locked)) |-> $stable(phy_addr));

  assert_reserved_refused_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_sel == 2'd0 && reg_wdata[0] && !busy && phy_addr == 5'h1F) |=> (!busy && req_err));

  assert_accept_starts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_sel == 2'd0 && reg_wdata[0] && !busy && phy_addr != 5'h1F) |=> (busy && !req_err));

  assert_idle_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);

  assert_idle_mdc_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  assert_mdio_steady_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_ends_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_busy_writes_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr_en && !frame_end) |=> $stable(rd_data));
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .busy(busy), .done(done), .req_err(req_err),
  .rd_data(rd_data), .phy_addr(phy_addr), .mdc(mdc), .mdio_o(mdio_o),
  .mdio_oe(mdio_oe), .cfg_locked(cfg_locked), .frame_end(frame_end)
);

// File: tb/mdio_mgmt_ctrl_tb.sv
module mdio_mgmt_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [4:0]  cfg_phy_addr = '0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [15:0] reg_wdata = '0;
  logic        busy, done, req_err, mdc, mdio_o, mdio_oe;
  logic [15:0] rd_data;
  logic [4:0]  phy_addr;
  logic        mdio_i = 1'b1;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  int done_cnt = 0;

  // PHY model state
  logic        cap_clr = 1'b0;
  int          n = 0;
  logic [63:0] cap_o, cap_oe;
  logic [15:0] phy_resp = '0;
  int          t_r0 = 0, t_r1 = 0, t_f0 = 0;

  // {rd, reg[4:0], data[15:0], h[7:0]}
  localparam logic [29:0] VECS [0:5] = '{
    {1'b0, 5'h00, 16'hA5A5, 8'd0},
    {1'b0, 5'h1F, 16'h8001, 8'd3},
    {1'b1, 5'h02, 16'h1234, 8'd1},
    {1'b1, 5'h1E, 16'h0001, 8'd0},
    {1'b0, 5'h10, 16'h0000, 8'd2},
    {1'b1, 5'h00, 16'hF00F, 8'd2}
  };

  mdio_mgmt_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_phy_addr(cfg_phy_addr),
    .reg_wr_en(reg_wr_en), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .busy(busy), .done(done), .req_err(req_err), .rd_data(rd_data),
    .phy_addr(phy_addr), .mdc(mdc), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (done) done_cnt = done_cnt + 1;
  end

  always @(posedge mdc or posedge cap_clr) begin
    if (cap_clr) n = 0;
    else begin
      if (n < 64) begin
        cap_o[63-n]  = mdio_o;
        cap_oe[63-n] = mdio_oe;
      end
      if (n == 0) t_r0 = cyc;
      if (n == 1) t_r1 = cyc;
      n = n + 1;
    end
  end

  always @(negedge mdc) begin
    if (n == 1) t_f0 = cyc;
    mdio_i = (n >= 48 && n <= 63) ? phy_resp[63-n] : 1'b1;
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic load_cfg(input logic [4:0] a);
    @(negedge clk);
    cfg_phy_addr = a; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int k = 0; k < 6000 && !seen; k++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
  endtask

  task automatic arm_capture();
    cap_clr = 1'b1; #1; cap_clr = 1'b0;
  endtask

  function automatic logic [63:0] exp_frame(input bit rd, input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
    logic [63:0] f;
    f = {32'hFFFFFFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, ra, 2'b10, d};
    return f;
  endfunction

  function automatic logic [63:0] exp_mask(input bit rd);
    return rd ? {{46{1'b1}}, 18'b0} : {64{1'b1}};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL R8 watchdog expired actual=%0d expected=done", cyc);
    summary();
    $finish;
  end

  initial begin
    bit seen;
    int d0;
    logic [63:0] ef, em;
    do_reset();

    // R1 reset values
    check(busy == 0 && done == 0 && req_err == 0, "R1 status after reset", {busy, done, req_err}, 0);
    check(mdc == 0 && mdio_oe == 0, "R1 mdc/oe after reset", {mdc, mdio_oe}, 0);
    check(phy_addr == 5'h1F, "R1 phy_addr after reset", phy_addr, 5'h1F);

    // R3 request before configuration is refused
    arm_capture();
    reg_write(2'd0, 16'h0001);
    check(busy == 0 && req_err == 1, "R3 unconfigured request refused", {busy, req_err}, 2'b01);
    repeat (10) @(negedge clk);
    check(n == 0 && mdc == 0, "R3 no MDC activity on refusal", n, 0);

    // R2 capture once
    load_cfg(5'h05);
    check(phy_addr == 5'h05, "R2 first load captured", phy_addr, 5'h05);
    load_cfg(5'h0A);
    check(phy_addr == 5'h05, "R2 later load ignored", phy_addr, 5'h05);

    // Vector loop: R4 R5 R6 R7 R8
    foreach (VECS[i]) begin
      bit          rd;
      logic [4:0]  ra;
      logic [15:0] dv;
      logic [7:0]  h;
      {rd, ra, dv, h} = VECS[i];
      phy_resp = dv;
      reg_write(2'd2, rd ? 16'h5A5A : dv);
      reg_write(2'd1, {11'd0, ra});
      arm_capture();
      d0 = done_cnt;
      reg_write(2'd0, {h, 6'd0, rd, 1'b1});
      check(busy == 1 && req_err == 0, "R8 busy after accept, R3 err cleared", {busy, req_err}, 2'b10);
      wait_done(seen);
      check(seen && busy == 0, "R8 done with busy low", {seen, busy}, 2'b10);
      @(negedge clk);
      check(done == 0 && done_cnt == d0 + 1, "R8 single done pulse", done_cnt - d0, 1);
      check(mdc == 0, "R7 mdc low after frame", mdc, 0);
      em = exp_mask(rd);
      ef = exp_frame(rd, 5'h05, ra, dv);
      check(n == 64, "R4 64 rising edges", n, 64);
      check(cap_oe == em, rd ? "R6 read enable pattern" : "R5 write enable pattern", cap_oe, em);
      check((cap_o & em) == (ef & em), "R4 frame bits", cap_o & em, ef & em);
      check(t_r1 - t_r0 == 2 * (int'(h) + 1), "R7 MDC period", t_r1 - t_r0, 2 * (int'(h) + 1));
      check(t_f0 - t_r0 == int'(h) + 1, "R7 MDC high time", t_f0 - t_r0, int'(h) + 1);
      check(rd_data == dv, rd ? "R6 read data latched" : "R5 write data held", rd_data, dv);
    end

    // R9 writes while busy are ignored
    reg_write(2'd2, 16'h1111);
    reg_write(2'd1, 16'h0003);
    arm_capture();
    d0 = done_cnt;
    reg_write(2'd0, 16'h0100);
    reg_write(2'd0, 16'h0101);
    repeat (20) @(negedge clk);
    reg_write(2'd2, 16'h2222);
    reg_write(2'd1, 16'h0007);
    reg_write(2'd0, 16'h0003);
    check(rd_data == 16'h1111, "R9 data write during busy ignored", rd_data, 16'h1111);
    wait_done(seen);
    repeat (300) @(negedge clk);
    ef = exp_frame(1'b0, 5'h05, 5'h03, 16'h1111);
    check(cap_o == ef && n == 64, "R9 frame unchanged by busy writes", cap_o, ef);
    check(done_cnt == d0 + 1 && busy == 0, "R9 busy request started nothing", done_cnt - d0, 1);

    // R3 configured reserved address
    do_reset();
    load_cfg(5'h1F);
    arm_capture();
    reg_write(2'd0, 16'h0003);
    repeat (10) @(negedge clk);
    check(busy == 0 && req_err == 1 && n == 0, "R3 configured 1Fh refused", {busy, req_err}, 2'b01);

    summary();
    $finish;
  end
endmodule